// File: doc/BRIEF.md
# Thermal Frequency-Voltage Step Sequencer

This block moves a processing element between two operating points when an over-temperature flag asserts. Each operating point pairs a clock-ratio code with a supply voltage code. On the way down the ratio switches first, inside a fixed stall window during which bus traffic is held off. Interrupt edges that arrive inside that window are kept and delivered once the window closes. After the stall the voltage code walks toward its reduced value one code per step, with a settle dwell between steps, while the bus stays open.

Recovery is gated. The over-temperature condition must stay clear for a whole hysteresis window. Then the voltage code climbs back to nominal one code at a time. Only after that does the ratio switch back, inside the same kind of stall window. The operating-point inputs are taken into the output registers at reset and at each ratio switch or step. Reset is synchronous and active high.

Top module: `thermal_step_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `ratio_out` equals `nom_ratio`, `vid_out` equals `nom_vid`, and `bus_block` and `irq_pending` are 0.
- R2: At nominal, with `enable` and `over_temp` both high at a clock edge, `ratio_out` takes `red_ratio` and `bus_block` rises at that same edge. `vid_out` is unchanged. `ratio_out` never changes except at an edge where `bus_block` rises.
- R3: Every ratio switch holds `bus_block` high for exactly `STALL_CYC` consecutive cycles. `bus_block` is 0 at every cycle in which `vid_out` changes.
- R4: `vid_out` changes by exactly +1 or -1 per step toward the target and never skips a code. A step happens `DWELL_CYC` cycles after the stall ends or after the previous step.
- R5: The downward voltage walk starts only after `bus_block` has fallen. The codes run in strict order from `nom_vid` to `red_vid`.
- R6: A rising edge on `irq_in` while `bus_block` is high is held. `irq_pending` rises one cycle after `bus_block` falls and never in a cycle that follows a blocked cycle.
- R7: A rising edge on `irq_in` while `bus_block` is low sets `irq_pending` on the next cycle. A high `irq_ack` clears it, unless a new edge is being set in that same cycle, in which case the set wins.
- R8: From the reduced point, recovery begins only after `enable && over_temp` has been low for `HYST_CYC` consecutive cycles. If the condition returns inside that window, the window is cancelled and the reduced point is kept. The first upward step appears `HYST_CYC + DWELL_CYC + 1` cycles after the condition was first seen low.
- R9: On recovery, `vid_out` reaches `nom_vid` before `ratio_out` returns to `nom_ratio`. That ratio switch uses the same `STALL_CYC` blocking stall.
- R10: With `enable` low, `over_temp` has no effect: `ratio_out` and `bus_block` stay at their nominal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows thermal throttling |
| over_temp | input | 1 | Temperature above trip point |
| nom_ratio | input | RATIO_W | Ratio code of the nominal point |
| nom_vid | input | VID_W | Voltage code of the nominal point |
| red_ratio | input | RATIO_W | Ratio code of the reduced point |
| red_vid | input | VID_W | Voltage code of the reduced point |
| irq_in | input | 1 | Edge-triggered interrupt request |
| irq_ack | input | 1 | Clears the pending interrupt |
| ratio_out | output | RATIO_W | Current ratio code (registered) |
| vid_out | output | VID_W | Current voltage code (registered) |
| bus_block | output | 1 | High while bus requests are refused |
| irq_pending | output | 1 | Interrupt waiting for acknowledge |

## Verification
The bench builds the sequencer with `STALL_CYC`=8, `DWELL_CYC`=3, `HYST_CYC`=6, and voltage codes 40 and 34. With these short windows the stall length, the dwell spacing and the hysteresis delay can each be counted in cycles. The bench also runs a full six-code walk down and back up and a cancelled recovery. A one-cycle interrupt pulse lands inside the stall, and the bench confirms that it is released only after the stall ends.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [2:0] {
    ST_NOMINAL,
    ST_DN_STALL,
    ST_DN_WALK,
    ST_REDUCED,
    ST_COOLDOWN,
    ST_UP_WALK,
    ST_UP_STALL
  } seq_state_t;
endpackage

// File: rtl/tss_countdown.sv
module tss_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/tss_vid_walker.sv
module tss_vid_walker #(
  parameter int VID_W     = 6,
  parameter int DWELL_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] init_vid,
  input  logic             run,
  input  logic [VID_W-1:0] target,
  output logic [VID_W-1:0] vid,
  output logic             at_target
);
  localparam int DW = (DWELL_CYC > 1) ? $clog2(DWELL_CYC + 1) : 1;
  localparam logic [DW-1:0] DWELL_LOAD = DW'(DWELL_CYC - 1);

  logic [DW-1:0] dwell;

  assign at_target = (vid == target);

  always_ff @(posedge clk) begin
    if (rst) begin
      vid   <= init_vid;
      dwell <= DWELL_LOAD;
    end else if (!run) begin
      dwell <= DWELL_LOAD;
    end else if (!at_target) begin
      if (dwell == '0) begin
        vid   <= (target > vid) ? vid + 1'b1 : vid - 1'b1;
        dwell <= DWELL_LOAD;
      end else begin
        dwell <= dwell - 1'b1;
      end
    end
  end

  // R4
  vid_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vid != $past(vid)) |-> ((vid == $past(vid) + VID_W'(1)) || (vid == $past(vid) - VID_W'(1))));
endmodule

// File: rtl/tss_irq_hold.sv
module tss_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic stall,
  input  logic ack,
  output logic pending
);
  logic prev, held, edge_seen, deliver;

  assign edge_seen = irq_in & ~prev;
  assign deliver   = ~stall & (edge_seen | held);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      held    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev    <= irq_in;
      held    <= stall & (held | edge_seen);
      pending <= (pending & ~ack) | deliver;
    end
  end

  // R6
  no_release_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pending) |-> !$past(stall));
endmodule

// File: rtl/thermal_step_seq.sv
module thermal_step_seq #(
  parameter int RATIO_W   = 5,
  parameter int VID_W     = 6,
  parameter int STALL_CYC = 1000,
  parameter int DWELL_CYC = 64,
  parameter int HYST_CYC  = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               over_temp,
  input  logic [RATIO_W-1:0] nom_ratio,
  input  logic [VID_W-1:0]   nom_vid,
  input  logic [RATIO_W-1:0] red_ratio,
  input  logic [VID_W-1:0]   red_vid,
  input  logic               irq_in,
  input  logic               irq_ack,
  output logic [RATIO_W-1:0] ratio_out,
  output logic [VID_W-1:0]   vid_out,
  output logic               bus_block,
  output logic               irq_pending
);
  import tss_pkg::*;

  localparam int MAXT = (STALL_CYC > HYST_CYC) ? STALL_CYC : HYST_CYC;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int BW   = $clog2(STALL_CYC + 2);

  seq_state_t    state;
  logic          hot, tmr_load, tmr_zero, walk_run, walk_done;
  logic [TW-1:0] tmr_val;
  logic [VID_W-1:0] walk_target;

  assign hot = enable & over_temp;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(STALL_CYC - 1);
    unique case (state)
      ST_NOMINAL: tmr_load = hot;
      ST_REDUCED: begin
        tmr_load = ~hot;
        tmr_val  = TW'(HYST_CYC - 1);
      end
      ST_UP_WALK: tmr_load = walk_done;
      default:    tmr_load = 1'b0;
    endcase
  end

  assign walk_run    = (state == ST_DN_WALK) || (state == ST_UP_WALK);
  assign walk_target = (state == ST_UP_WALK) ? nom_vid : red_vid;

  tss_countdown #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  tss_vid_walker #(.VID_W(VID_W), .DWELL_CYC(DWELL_CYC)) u_walk (
    .clk(clk), .rst(rst), .init_vid(nom_vid), .run(walk_run),
    .target(walk_target), .vid(vid_out), .at_target(walk_done)
  );

  tss_irq_hold u_irq (
    .clk(clk), .rst(rst), .irq_in(irq_in), .stall(bus_block),
    .ack(irq_ack), .pending(irq_pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_NOMINAL;
      ratio_out <= nom_ratio;
      bus_block <= 1'b0;
    end else begin
      unique case (state)
        ST_NOMINAL: if (hot) begin
          ratio_out <= red_ratio;
          bus_block <= 1'b1;
          state     <= ST_DN_STALL;
        end
        ST_DN_STALL: if (tmr_zero) begin
          bus_block <= 1'b0;
          state     <= ST_DN_WALK;
        end
        ST_DN_WALK:  if (walk_done) state <= ST_REDUCED;
        ST_REDUCED:  if (!hot) state <= ST_COOLDOWN;
        ST_COOLDOWN: begin
          if (hot)           state <= ST_REDUCED;
          else if (tmr_zero) state <= ST_UP_WALK;
        end
        ST_UP_WALK: if (walk_done) begin
          ratio_out <= nom_ratio;
          bus_block <= 1'b1;
          state     <= ST_UP_STALL;
        end
        ST_UP_STALL: if (tmr_zero) begin
          bus_block <= 1'b0;
          state     <= ST_NOMINAL;
        end
        default: state <= ST_NOMINAL;
      endcase
    end
  end

  logic [BW-1:0] block_run;
  always_ff @(posedge clk) begin
    if (rst)            block_run <= '0;
    else if (bus_block) block_run <= block_run + 1'b1;
    else                block_run <= '0;
  end

  // R2
  ratio_with_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_out != $past(ratio_out)) |-> (bus_block && !$past(bus_block)));

  // R3
  stall_len_chk: assert property (@(posedge clk) disable iff (rst)
    block_run <= BW'(STALL_CYC));

  // R3
  open_bus_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (vid_out != $past(vid_out)) |-> !bus_block);

  // R9
  ratio_up_after_vid_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UP_STALL && $past(state) == ST_UP_WALK) |-> (vid_out == nom_vid));
endmodule

// File: tb/thermal_step_seq_test.sv
module thermal_step_seq_test;
  localparam int RW = 5, VW = 6, STALL = 8, DWELL = 3, HYST = 6;
  localparam logic [RW-1:0] NOM_R = 5'd20, RED_R = 5'd12;
  localparam logic [VW-1:0] NOM_V = 6'd40, RED_V = 6'd34;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, over_temp = 1'b0;
  logic irq_in = 1'b0, irq_ack = 1'b0;
  logic [RW-1:0] ratio_out;
  logic [VW-1:0] vid_out;
  logic bus_block, irq_pending;

  int compared = 0, mismatched = 0;
  int exp_q[$];
  logic [VW-1:0] last_vid = NOM_V;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  thermal_step_seq #(.RATIO_W(RW), .VID_W(VW), .STALL_CYC(STALL),
                     .DWELL_CYC(DWELL), .HYST_CYC(HYST)) uut (
    .clk(clk), .rst(rst), .enable(enable), .over_temp(over_temp),
    .nom_ratio(NOM_R), .nom_vid(NOM_V), .red_ratio(RED_R), .red_vid(RED_V),
    .irq_in(irq_in), .irq_ack(irq_ack), .ratio_out(ratio_out),
    .vid_out(vid_out), .bus_block(bus_block), .irq_pending(irq_pending)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_walk(int from, int to);
    for (int v = from; v != to; ) begin
      v = (to > v) ? v + 1 : v - 1;
      exp_q.push_back(v);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every voltage code change is compared to the queue
  always @(negedge clk) begin
    if (!rst && vid_out != last_vid) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected step", int'(vid_out), int'(last_vid));
      end else begin
        chk("R4/R5 step order", int'(vid_out), exp_q.pop_front());
        chk("R3 bus open on step", int'(bus_block), 0);
      end
      last_vid = vid_out;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    int n;
    int max_bb;
    tick(3);
    // R1 reset state, checked while reset is still high
    chk("R1 ratio", int'(ratio_out), int'(NOM_R));
    chk("R1 vid", int'(vid_out), int'(NOM_V));
    chk("R1 bus_block", int'(bus_block), 0);
    chk("R1 pending", int'(irq_pending), 0);
    rst = 1'b0;
    tick();
    // R1 first cycle after reset
    chk("R1 ratio after release", int'(ratio_out), int'(NOM_R));

    // R10: over_temp ignored with enable low
    over_temp = 1'b1;
    max_bb = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (bus_block) max_bb = 1;
    end
    chk("R10 bus_block", max_bb, 0);
    chk("R10 ratio", int'(ratio_out), int'(NOM_R));
    over_temp = 1'b0;

    // R7: edge outside stall, then acknowledge
    irq_in = 1'b1; tick(); irq_in = 1'b0;
    chk("R7 pending set", int'(irq_pending), 1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R7 pending cleared", int'(irq_pending), 0);

    // R2/R3/R5/R6: throttle down
    push_walk(NOM_V, RED_V);
    enable = 1'b1; over_temp = 1'b1;
    tick();
    chk("R2 ratio reduced", int'(ratio_out), int'(RED_R));
    chk("R2 bus_block", int'(bus_block), 1);
    chk("R2 vid unchanged", int'(vid_out), int'(NOM_V));
    irq_in = 1'b1;
    n = 1;
    tick(); irq_in = 1'b0;
    while (bus_block && n < 100) begin
      if (irq_pending) chk("R6 held during stall", 1, 0);
      n++;
      tick();
    end
    chk("R3 stall length", n, STALL);
    chk("R6 not yet released", int'(irq_pending), 0);
    chk("R5 vid before walk", int'(vid_out), int'(NOM_V));
    tick();
    chk("R6 released after stall", int'(irq_pending), 1);
    irq_ack = 1'b1;
    n = 1;
    while (vid_out == NOM_V && n < 100) begin tick(); irq_ack = 1'b0; n++; end
    chk("R4 first dwell", n, DWELL);
    n = 0;
    while (vid_out == NOM_V - 6'd1 && n < 100) begin tick(); n++; end
    chk("R4 dwell between steps", n, DWELL);
    n = 0;
    while (vid_out != RED_V && n < 200) begin tick(); n++; end
    chk("R5 reached reduced vid", int'(vid_out), int'(RED_V));
    tick(3);

    // R8: cancelled cool-down keeps reduced point
    over_temp = 1'b0; tick(3); over_temp = 1'b1;
    tick(20);
    chk("R8 vid held", int'(vid_out), int'(RED_V));
    chk("R8 ratio held", int'(ratio_out), int'(RED_R));

    // R8/R9: real recovery
    push_walk(RED_V, NOM_V);
    over_temp = 1'b0;
    n = 0;
    while (vid_out == RED_V && n < 100) begin tick(); n++; end
    chk("R8 hysteresis delay", n, HYST + DWELL + 1);
    n = 0;
    max_bb = 0;
    while (!bus_block && n < 200) begin
      if (ratio_out != RED_R) max_bb = 1;
      tick(); n++;
    end
    chk("R9 ratio held during climb", max_bb, 0);
    chk("R9 vid nominal at switch", int'(vid_out), int'(NOM_V));
    chk("R9 ratio restored", int'(ratio_out), int'(NOM_R));
    n = 0;
    while (bus_block && n < 100) begin tick(); n++; end
    chk("R9 return stall length", n, STALL);
    chk("R4 all steps seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule